// File: doc/BRIEF.md
# Paired-Word Stream Link With End Token

This block moves a block of scalar words from a source memory to a destination memory through a token stream. The producer side reads `2n` consecutive words from a synchronous read port that has one cycle of latency. It packs each consecutive pair of words into one two-lane token and pushes that token into an internal FIFO. After the last data token it pushes one extra token marked as end-of-transaction. Each FIFO entry carries a flag bit beside the data, and that flag marks the end token.

The consumer side looks at the FIFO head without removing it. A data token at the head becomes two writes on the destination port, the low lane first and then the high lane. Only after both writes have been accepted is the token popped. An end token at the head is popped and raises `done`. The consumer never sees the count `n`. The end token alone ends its loop.

A run begins with a `start` pulse while both sides are idle, and `n_tokens` is sampled at that moment. The destination port has a ready input. While a write is not accepted, the consumer holds the write steady. Back-pressure then fills the FIFO, and the producer waits with its token held.

Top module: `pair_stream_link`

## Requirements
- R1: The source word at address `2i` is written to destination address `2i` and the word at `2i+1` to `2i+1`; lane 0 of token `i` holds the even word and lane 1 the odd word.
- R2: A run with count `n` produces exactly `2n` accepted destination writes, at addresses 0, 1, ..., `2n-1` in ascending order.
- R3: Once `done` is high, no destination write is issued and the FIFO is empty; `done` rises only when the end token has been taken from the head.
- R4: For each data token, the write of lane 0 to the even address is accepted before lane 1 is written to the next odd address, and the odd write is presented in the cycle after the even write is accepted.
- R5: With `n` = 0, no source read and no destination write occurs, and `done` still rises.
- R6: While the destination port is not ready, the pending write holds its address and data. While the FIFO is full, the producer holds its token. No word is lost or repeated under back-pressure.
- R7: `done` is low out of reset. It is cleared by an accepted `start`, goes high after the end token is consumed, and stays high until the next accepted `start`.
- R8: A `start` pulse while a run is in progress is ignored. `n_tokens` is sampled only when `start` is accepted.
- R9: Source reads are issued once per word at ascending addresses 0 to `2n-1`. Each odd address is read in the cycle after its even partner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run when both sides are idle |
| n_tokens | input | AW | Number of word pairs to move, sampled at accepted start |
| src_rd_en | output | 1 | Source read request |
| src_addr | output | AW | Source word address |
| src_rd_data | input | DW | Source data, valid one cycle after the request |
| dst_wr_en | output | 1 | Destination write request |
| dst_addr | output | AW | Destination word address |
| dst_wr_data | output | DW | Destination write data |
| dst_wr_ready | input | 1 | Destination accepts the write this cycle |
| done | output | 1 | End token consumed; run finished |

## Verification
The block is run with pair counts of zero, one, a few and many. The zero case shows whether the end token is sent on its own without reads. The one-pair case exposes off-by-one faults in the end-token timing. The longer runs use distinct word values per address, so swapped lanes or shifted addresses stand out. One long run uses a destination that is mostly not ready, which drives the FIFO full and shows whether held tokens and held writes survive back-pressure. Another run receives a second `start` and a changed count in the middle of the transfer, which tells an ignored restart apart from one that corrupts the run.

// File: rtl/pslink_pkg.sv
// Shared state encodings for the paired-word stream link.
// Assumes nothing beyond being compiled before the modules that import it.
package pslink_pkg;

    typedef enum logic [2:0] {
        PR_IDLE,
        PR_RD_LO,
        PR_RD_HI,
        PR_CAPTURE,
        PR_PUSH,
        PR_MARK
    } prod_state_e;

    typedef enum logic [1:0] {
        CN_IDLE,
        CN_WR_LO,
        CN_WR_HI
    } cons_state_e;

endpackage

// File: rtl/pslink_producer.sv
// Producer: reads 2n words from a one-cycle-latency memory port, packs each
// pair into a two-lane token, pushes n tokens and then one end token.
// Assumes: go is a single-cycle pulse while idle; n <= 2**(AW-1).
module pslink_producer
    import pslink_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] n_tokens,
    input  logic          fifo_full,
    output logic          src_rd_en,
    output logic [AW-1:0] src_addr,
    input  logic [DW-1:0] src_rd_data,
    output logic          tok_valid,
    output logic          tok_push,
    output logic [DW-1:0] tok_lane0,
    output logic [DW-1:0] tok_lane1,
    output logic          tok_eot,
    output logic          idle
);

    prod_state_e   state;
    logic [AW-1:0] pair_idx;
    logic [AW-1:0] n_lat;
    logic [DW-1:0] lane0_q;
    logic [DW-1:0] lane1_q;

    // Decode read requests and token presentation from the state.
    always_comb begin
        src_rd_en = (state == PR_RD_LO) || (state == PR_RD_HI);
        src_addr  = {pair_idx[AW-2:0], (state == PR_RD_HI)};
        tok_valid = (state == PR_PUSH) || (state == PR_MARK);
        tok_eot   = (state == PR_MARK);
        tok_lane0 = (state == PR_MARK) ? '0 : lane0_q;
        tok_lane1 = (state == PR_MARK) ? '0 : lane1_q;
        tok_push  = tok_valid && !fifo_full;
        idle      = (state == PR_IDLE);
    end

    // Sequence reads, capture the returned words and advance the pair index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PR_IDLE;
            pair_idx <= '0;
            n_lat    <= '0;
            lane0_q  <= '0;
            lane1_q  <= '0;
        end else begin
            case (state)
                PR_IDLE: begin
                    if (go) begin
                        n_lat    <= n_tokens;
                        pair_idx <= '0;
                        state    <= (n_tokens == '0) ? PR_MARK : PR_RD_LO;
                    end
                end
                PR_RD_LO:   state <= PR_RD_HI;
                PR_RD_HI: begin
                    lane0_q <= src_rd_data;
                    state   <= PR_CAPTURE;
                end
                PR_CAPTURE: begin
                    lane1_q <= src_rd_data;
                    state   <= PR_PUSH;
                end
                PR_PUSH: begin
                    if (!fifo_full) begin
                        pair_idx <= pair_idx + AW'(1);
                        state    <= (pair_idx + AW'(1) == n_lat) ? PR_MARK : PR_RD_LO;
                    end
                end
                PR_MARK: begin
                    if (!fifo_full) state <= PR_IDLE;
                end
                default: state <= PR_IDLE;
            endcase
        end
    end

    // R6: a token refused by a full FIFO stays presented and unchanged.
    p_hold_token_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && fifo_full) |=> (tok_valid && $stable(tok_lane0)
                                      && $stable(tok_lane1) && $stable(tok_eot)));

    // R9: an odd-address read directly follows its even partner.
    p_read_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd_en && src_addr[0]) |-> ($past(src_rd_en)
                                        && ($past(src_addr) + AW'(1) == src_addr)));

endmodule

// File: rtl/pslink_fifo.sv
// Synchronous FIFO with a combinational head view (peek without removal).
// Assumes: DEPTH >= 2; callers never push when full nor pop when empty.
module pslink_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW:0]   count;

    // Status and head view.
    always_comb begin
        empty = (count == '0);
        full  = (count == (PW+1)'(DEPTH));
        head  = store[rd_ptr];
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + PW'(1);
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + PW'(1);
            case ({push, pop})
                2'b10:   count <= count + (PW+1)'(1);
                2'b01:   count <= count - (PW+1)'(1);
                default: count <= count;
            endcase
        end
    end

    // Entry storage; no reset needed, occupancy guards reads.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    // R6: the producer must wait rather than push into a full FIFO.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R3: the consumer only removes entries that exist.
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/pslink_consumer.sv
// Consumer: peeks the FIFO head; a data token becomes two writes (lane 0 to
// 2i, lane 1 to 2i+1) and is popped after the second; an end token is
// popped and sets done. Holds no copy of the pair count.
// Assumes: go is a single-cycle pulse while idle.
module pslink_consumer
    import pslink_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          fifo_empty,
    input  logic [DW-1:0] head_lane0,
    input  logic [DW-1:0] head_lane1,
    input  logic          head_eot,
    output logic          pop,
    output logic          dst_wr_en,
    output logic [AW-1:0] dst_addr,
    output logic [DW-1:0] dst_wr_data,
    input  logic          dst_wr_ready,
    output logic          done,
    output logic          idle
);

    cons_state_e   state;
    logic [AW-1:0] idx;

    // Decode write requests and pops from the state and the peeked head.
    always_comb begin
        dst_wr_en   = 1'b0;
        pop         = 1'b0;
        dst_addr    = {idx[AW-2:0], 1'b0};
        dst_wr_data = head_lane0;
        idle        = (state == CN_IDLE);
        case (state)
            CN_WR_LO: begin
                dst_wr_en = !fifo_empty && !head_eot;
                pop       = !fifo_empty && head_eot;
            end
            CN_WR_HI: begin
                dst_wr_en   = 1'b1;
                dst_addr    = {idx[AW-2:0], 1'b1};
                dst_wr_data = head_lane1;
                pop         = dst_wr_ready;
            end
            default: ;
        endcase
    end

    // Walk each token through its two writes and stop on the end token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CN_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                CN_IDLE: begin
                    if (go) begin
                        idx   <= '0;
                        done  <= 1'b0;
                        state <= CN_WR_LO;
                    end
                end
                CN_WR_LO: begin
                    if (!fifo_empty) begin
                        if (head_eot) begin
                            done  <= 1'b1;
                            state <= CN_IDLE;
                        end else if (dst_wr_ready) begin
                            state <= CN_WR_HI;
                        end
                    end
                end
                CN_WR_HI: begin
                    if (dst_wr_ready) begin
                        idx   <= idx + AW'(1);
                        state <= CN_WR_LO;
                    end
                end
                default: state <= CN_IDLE;
            endcase
        end
    end

    // R4: the odd-address write follows an accepted even-address write.
    p_write_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_wr_en && dst_addr[0] && !$past(dst_addr[0])) |->
            ($past(dst_wr_en) && $past(dst_wr_ready)
             && ($past(dst_addr) + AW'(1) == dst_addr)));

    // R6: a write the port did not accept is held unchanged.
    p_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_wr_en && !dst_wr_ready) |=> (dst_wr_en && $stable(dst_addr)
                                          && $stable(dst_wr_data)));

    // R3: no destination write once the run has finished.
    p_quiet_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dst_wr_en);

endmodule

// File: rtl/pair_stream_link.sv
// Top: producer, token FIFO with an end flag beside each entry, consumer.
// Accepts start only when both sides are idle.
// Assumes: FIFO_DEPTH is at least 2; n_tokens <= 2**(AW-1).
module pair_stream_link #(
    parameter int DW         = 16,
    parameter int AW         = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] n_tokens,
    output logic          src_rd_en,
    output logic [AW-1:0] src_addr,
    input  logic [DW-1:0] src_rd_data,
    output logic          dst_wr_en,
    output logic [AW-1:0] dst_addr,
    output logic [DW-1:0] dst_wr_data,
    input  logic          dst_wr_ready,
    output logic          done
);

    localparam int TW = 2*DW + 1;

    logic          prod_idle, cons_idle, go;
    logic          tok_valid, tok_push, tok_eot;
    logic [DW-1:0] tok_lane0, tok_lane1;
    logic [TW-1:0] head;
    logic          fifo_empty, fifo_full, pop;

    // Accept a start only when neither side is busy.
    always_comb go = start && prod_idle && cons_idle;

    pslink_producer #(.DW(DW), .AW(AW)) u_prod (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .n_tokens   (n_tokens),
        .fifo_full  (fifo_full),
        .src_rd_en  (src_rd_en),
        .src_addr   (src_addr),
        .src_rd_data(src_rd_data),
        .tok_valid  (tok_valid),
        .tok_push   (tok_push),
        .tok_lane0  (tok_lane0),
        .tok_lane1  (tok_lane1),
        .tok_eot    (tok_eot),
        .idle       (prod_idle)
    );

    pslink_fifo #(.W(TW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (tok_push),
        .push_data({tok_eot, tok_lane1, tok_lane0}),
        .pop      (pop),
        .head     (head),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    pslink_consumer #(.DW(DW), .AW(AW)) u_cons (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .fifo_empty  (fifo_empty),
        .head_lane0  (head[DW-1:0]),
        .head_lane1  (head[2*DW-1:DW]),
        .head_eot    (head[TW-1]),
        .pop         (pop),
        .dst_wr_en   (dst_wr_en),
        .dst_addr    (dst_addr),
        .dst_wr_data (dst_wr_data),
        .dst_wr_ready(dst_wr_ready),
        .done        (done),
        .idle        (cons_idle)
    );

    // R3: done rises only after the end token has left the FIFO.
    p_done_drained_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> fifo_empty);

    // R7: done holds until a new start arrives.
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R8: nothing is read or popped while no run is in progress.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_idle && cons_idle) |-> (!src_rd_en && !pop));

endmodule

// File: tb/pair_stream_link_bench.sv
module pair_stream_link_bench;

    localparam int DW = 16;
    localparam int AW = 8;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] n_tokens = '0;
    logic          src_rd_en;
    logic [AW-1:0] src_addr;
    logic [DW-1:0] src_rd_data = '0;
    logic          dst_wr_en;
    logic [AW-1:0] dst_addr;
    logic [DW-1:0] dst_wr_data;
    logic          dst_wr_ready = 1'b1;
    logic          done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wr_count = 0;
    int rd_count = 0;
    logic stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [DW-1:0] src_mem [NW];
    logic [AW+DW-1:0] exp_q [$];

    always #2.5 clk = ~clk;

    pair_stream_link #(.DW(DW), .AW(AW), .FIFO_DEPTH(4)) u_pair_stream_link (
        .clk(clk), .rst_n(rst_n), .start(start), .n_tokens(n_tokens),
        .src_rd_en(src_rd_en), .src_addr(src_addr), .src_rd_data(src_rd_data),
        .dst_wr_en(dst_wr_en), .dst_addr(dst_addr), .dst_wr_data(dst_wr_data),
        .dst_wr_ready(dst_wr_ready), .done(done)
    );

    // Source memory with one cycle of read latency; ready pattern generator.
    always @(posedge clk) begin
        if (src_rd_en) src_rd_data <= src_mem[src_addr];
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        dst_wr_ready <= stall_mode ? (lfsr[0] & lfsr[3]) : 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_bench();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Monitor: reads must climb 0,1,2...; writes are popped from the scoreboard.
    always @(negedge clk) begin
        if (rst_n && src_rd_en) begin
            check(src_addr == AW'(rd_count), "R9", "read address",
                  int'(src_addr), rd_count);
            rd_count++;
        end
        if (rst_n && dst_wr_en && dst_wr_ready) begin
            wr_count++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected write address", int'(dst_addr), -1);
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                check(dst_addr == e[AW+DW-1:DW], "R2", "write address",
                      int'(dst_addr), int'(e[AW+DW-1:DW]));
                check(dst_wr_data == e[DW-1:0], "R1", "write data",
                      int'(dst_wr_data), int'(e[DW-1:0]));
            end
        end
    end

    // Watchdog over the whole run.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "R7", "watchdog expired", cyc, 150000);
            finish_bench();
        end
    end

    // Driver: fill the source, queue the expected writes, start and wait.
    task automatic run(input int n, input int seed, input bit stall,
                       input bit restart);
        int waited;
        for (int k = 0; k < NW; k++)
            src_mem[k] = DW'((k * 37 + seed * 101) ^ 16'hA5C3);
        for (int k = 0; k < 2 * n; k++)
            exp_q.push_back({AW'(k), src_mem[k]});
        wr_count = 0;
        rd_count = 0;
        stall_mode = stall;
        @(negedge clk);
        n_tokens = AW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R7", "done cleared by start", int'(done), 0);
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (restart && waited == 10) begin
                n_tokens = AW'(3);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                waited++;
            end
        end
        check(done == 1'b1, "R7", "done reached", int'(done), 1);
        begin
            int wr_at_done;
            wr_at_done = wr_count;
            repeat (5) @(negedge clk);
            check(wr_count == wr_at_done, "R3", "writes after done",
                  wr_count, wr_at_done);
            check(done == 1'b1, "R7", "done held", int'(done), 1);
        end
        check(wr_count == 2 * n, restart ? "R8" : "R2", "write count",
              wr_count, 2 * n);
        check(rd_count == 2 * n, "R9", "read count", rd_count, 2 * n);
        check(exp_q.size() == 0, "R6", "items left in scoreboard",
              exp_q.size(), 0);
        exp_q.delete();
        stall_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R7", "reset done", int'(done), 0);
        check(src_rd_en == 1'b0, "R9", "reset read enable", int'(src_rd_en), 0);
        check(dst_wr_en == 1'b0, "R3", "reset write enable", int'(dst_wr_en), 0);

        run(0, 1, 1'b0, 1'b0);   // R5: end token only
        check(rd_count == 0 && wr_count == 0, "R5", "zero-count traffic",
              rd_count + wr_count, 0);
        run(1, 2, 1'b0, 1'b0);   // R1, R4: single pair
        run(5, 3, 1'b0, 1'b0);   // R2: short block
        run(40, 4, 1'b1, 1'b0);  // R6: heavy back-pressure fills the FIFO
        run(6, 5, 1'b0, 1'b1);   // R8: restart and count change mid-run
        run(2, 6, 1'b1, 1'b0);   // R4, R6: short block under stalls
        finish_bench();
    end

endmodule